// File: doc/BRIEF.md
# Serial-Bus Port Expander Target

This block is a 7-bit-addressed target for a two-wire serial bus (I2C). A fast system clock oversamples the bus. The block drives one 8-bit output latch toward a parallel port and keeps one 8-bit capture register loaded from the port pins. A controller writes bytes to the latch or reads captured bytes back. Every byte moves in its own framed transfer.

SCL and SDA pass through synchronisers. Their edges are found in the system clock domain. The block pulls SDA low only through an output enable, and the pad outside turns that enable into an open-drain pull-down. It detects START, repeated START and STOP conditions, counts the bits of each byte, and checks the address against a family code plus three strap pins. It updates the port and recaptures input only at fixed edges of the acknowledge clock. One-cycle strobes mark the acknowledge phases, every port update and every capture, so that a neighbouring interrupt block can tell when the port was serviced. The system clock must run at least 16 times faster than SCL.

Top module: `pex_i2c_target`

## Requirements
- R1: The 7-bit address is a 4-bit family code followed by strap_i[2:0]. The family code is 0100 by default and 0111 when ALT_FAMILY=1. Address bits arrive MSB first, then the R/W bit (1 = read). SDA is pulled low in the ninth clock only when the address matches.
- R2: The address is compared with the straps when the falling SCL edge of the R/W bit is seen. A strap change made before that edge decides the outcome.
- R3: In a write, port_out_o takes the received byte when the rising SCL edge of the data acknowledge clock is seen. It does not change earlier in that clock. Every further complete byte before STOP is acknowledged and loads the latch again. An incomplete byte never changes the port.
- R4: In a read, capture_o loads port_in_i at the rising SCL edge of the address acknowledge clock. The captured byte is then shifted out MSB first, starting after the falling edge of that clock.
- R5: During a read, a controller ACK (SDA low) on a data byte recaptures the port at the rising edge of that acknowledge clock, and the next byte carries the new value. A NACK leaves capture_o unchanged, and SDA is not driven afterwards.
- R6: START or repeated START abandons any partial address, and a full matching address is then needed for a response.
- R7: After STOP the block is idle. SCL pulses with no new START give no acknowledge and do not change the port.
- R8: addr_ack_o and data_ack_o pulse for one cycle at the rising edge of each address and data acknowledge clock. The two never pulse together. update_p_o pulses with every latch load, and capture_p_o pulses with every capture. rd_xfer_o is 1 during a read transfer and 0 during a write.
- R9: While reset is held, port_out_o is all ones, capture_o is zero and SDA is released.
- R10: The SDA output enable changes only after a falling SCL edge, or on a START or STOP condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 3 | Low three address bits |
| port_in_i | input | DATA_W | Parallel port pin levels |
| port_out_o | output | DATA_W | Output latch |
| capture_o | output | DATA_W | Input capture register |
| addr_ack_o | output | 1 | Pulse at the address acknowledge rising edge |
| data_ack_o | output | 1 | Pulse at a data acknowledge rising edge |
| capture_p_o | output | 1 | Pulse when capture_o loads |
| update_p_o | output | 1 | Pulse when port_out_o loads |
| rd_xfer_o | output | 1 | Direction of the current transfer, 1 = read |

## Verification
The bench sweeps every strap setting against every address in the family and against the other family. A wrong family code or strap compare shows up as a missing or extra acknowledge. It changes the straps while the R/W bit is on the bus: a design that latched the address early would acknowledge the wrong address. It samples the port just before and just after the rising edge of the data acknowledge, stops a byte halfway through, and clocks bits after STOP with no new START. A latch that loaded early, accepted partial bytes or stayed awake would show a port change there. On reads it changes the pins between bytes and then NACKs. A missing recapture, a recapture after NACK or SDA still driven after NACK each produces a wrong read value.

// File: rtl/pex_pkg.sv
package pex_pkg;
   typedef enum logic [2:0] {
      PX_IDLE,
      PX_ADDR,
      PX_AACK,
      PX_WBIT,
      PX_WACK,
      PX_RBIT,
      PX_RACK
   } px_state_t;

   localparam logic [3:0] PX_FAM_BASE = 4'b0100;
   localparam logic [3:0] PX_FAM_ALT  = 4'b0111;
endpackage

// File: rtl/pex_line_sync.sv
module pex_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] pipe_q;
   logic              prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("pex_line_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pipe_q <= '1;
         prev_q <= 1'b1;
      end else begin
         pipe_q <= {pipe_q[STAGES-2:0], line_i};
         prev_q <= pipe_q[STAGES-1];
      end
   end

   assign lvl_o  = pipe_q[STAGES-1];
   assign rise_o = lvl_o & ~prev_q;
   assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/pex_addr_match.sv
module pex_addr_match #(
   parameter bit ALT_FAMILY = 1'b0
) (
   input  logic [6:0] rx_addr_i,
   input  logic [2:0] strap_i,
   output logic       hit_o
);
   import pex_pkg::*;
   logic [3:0] fam;

   if (ALT_FAMILY) begin : g_alt
      assign fam = PX_FAM_ALT;
   end else begin : g_base
      assign fam = PX_FAM_BASE;
   end

   assign hit_o = (rx_addr_i == {fam, strap_i});
endmodule

// File: rtl/pex_bus_engine.sv
module pex_bus_engine #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              sda_lvl_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              hit_i,
   input  logic [DATA_W-1:0] port_in_i,
   output logic [6:0]        rx_addr_o,
   output logic              sda_oe_o,
   output logic [DATA_W-1:0] port_out_o,
   output logic [DATA_W-1:0] capture_o,
   output logic              addr_ack_o,
   output logic              data_ack_o,
   output logic              capture_p_o,
   output logic              update_p_o,
   output logic              rd_xfer_o
);
   import pex_pkg::*;
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

   px_state_t         st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] sh_q;
   logic              rw_q;
   logic              more_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= PX_IDLE;
         cnt_q       <= '0;
         sh_q        <= '0;
         rw_q        <= 1'b0;
         more_q      <= 1'b0;
         sda_oe_o    <= 1'b0;
         port_out_o  <= '1;
         capture_o   <= '0;
         addr_ack_o  <= 1'b0;
         data_ack_o  <= 1'b0;
         capture_p_o <= 1'b0;
         update_p_o  <= 1'b0;
      end else begin
         addr_ack_o  <= 1'b0;
         data_ack_o  <= 1'b0;
         capture_p_o <= 1'b0;
         update_p_o  <= 1'b0;
         if (start_i) begin
            st_q     <= PX_ADDR;
            cnt_q    <= '0;
            sda_oe_o <= 1'b0;
         end else if (stop_i) begin
            st_q     <= PX_IDLE;
            sda_oe_o <= 1'b0;
         end else begin
            case (st_q)
               PX_ADDR: begin
                  if (scl_rise_i && cnt_q != LAST) begin
                     sh_q  <= {sh_q[DATA_W-2:0], sda_lvl_i};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall_i && cnt_q == LAST) begin
                     if (hit_i) begin
                        rw_q     <= sh_q[0];
                        sda_oe_o <= 1'b1;
                        st_q     <= PX_AACK;
                     end else begin
                        st_q <= PX_IDLE;
                     end
                  end
               end
               PX_AACK: begin
                  if (scl_rise_i) begin
                     addr_ack_o <= 1'b1;
                     if (rw_q) begin
                        capture_o   <= port_in_i;
                        capture_p_o <= 1'b1;
                     end
                  end else if (scl_fall_i) begin
                     cnt_q <= '0;
                     if (rw_q) begin
                        sh_q     <= capture_o;
                        sda_oe_o <= ~capture_o[DATA_W-1];
                        st_q     <= PX_RBIT;
                     end else begin
                        sda_oe_o <= 1'b0;
                        st_q     <= PX_WBIT;
                     end
                  end
               end
               PX_WBIT: begin
                  if (scl_rise_i && cnt_q != LAST) begin
                     sh_q  <= {sh_q[DATA_W-2:0], sda_lvl_i};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall_i && cnt_q == LAST) begin
                     sda_oe_o <= 1'b1;
                     st_q     <= PX_WACK;
                  end
               end
               PX_WACK: begin
                  if (scl_rise_i) begin
                     port_out_o <= sh_q;
                     update_p_o <= 1'b1;
                     data_ack_o <= 1'b1;
                  end else if (scl_fall_i) begin
                     sda_oe_o <= 1'b0;
                     cnt_q    <= '0;
                     st_q     <= PX_WBIT;
                  end
               end
               PX_RBIT: begin
                  if (scl_rise_i) begin
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall_i) begin
                     if (cnt_q == LAST) begin
                        sda_oe_o <= 1'b0;
                        st_q     <= PX_RACK;
                     end else begin
                        sh_q     <= {sh_q[DATA_W-2:0], 1'b0};
                        sda_oe_o <= ~sh_q[DATA_W-2];
                     end
                  end
               end
               PX_RACK: begin
                  if (scl_rise_i) begin
                     data_ack_o <= 1'b1;
                     more_q     <= ~sda_lvl_i;
                     if (!sda_lvl_i) begin
                        capture_o   <= port_in_i;
                        capture_p_o <= 1'b1;
                     end
                  end else if (scl_fall_i) begin
                     if (more_q) begin
                        sh_q     <= capture_o;
                        sda_oe_o <= ~capture_o[DATA_W-1];
                        cnt_q    <= '0;
                        st_q     <= PX_RBIT;
                     end else begin
                        st_q <= PX_IDLE;
                     end
                  end
               end
               default: st_q <= PX_IDLE;
            endcase
         end
      end
   end

   assign rx_addr_o = sh_q[DATA_W-1:1];
   assign rd_xfer_o = rw_q && (st_q != PX_IDLE) && (st_q != PX_ADDR);

   assert_oe_edges_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> $past(scl_fall_i || start_i || stop_i))
      else $error("SDA enable moved without SCL fall or bus condition");

   assert_latch_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(port_out_o) |-> update_p_o)
      else $error("port latch changed without update strobe");

   assert_capture_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(capture_o) |-> capture_p_o)
      else $error("capture changed without capture strobe");

   assert_ack_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_ack_o, data_ack_o}))
      else $error("address and data ack strobes together");

   assert_update_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      update_p_o |-> $past(scl_rise_i))
      else $error("port update away from SCL rise");
endmodule

// File: rtl/pex_i2c_target.sv
module pex_i2c_target #(
   parameter int DATA_W      = 8,
   parameter bit ALT_FAMILY  = 1'b0,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [2:0]        strap_i,
   input  logic [DATA_W-1:0] port_in_i,
   output logic [DATA_W-1:0] port_out_o,
   output logic [DATA_W-1:0] capture_o,
   output logic              addr_ack_o,
   output logic              data_ack_o,
   output logic              capture_p_o,
   output logic              update_p_o,
   output logic              rd_xfer_o
);
   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;
   logic start_det, stop_det, hit;
   logic [6:0] rx_addr;

   if (DATA_W != 8) begin : g_bad_width
      $error("pex_i2c_target: bytes on the bus are 8 bits, DATA_W must be 8");
   end

   pex_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i),
      .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

   pex_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i),
      .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

   assign start_det = scl_lvl & sda_fall;
   assign stop_det  = scl_lvl & sda_rise;

   pex_addr_match #(.ALT_FAMILY(ALT_FAMILY)) u_match (
      .rx_addr_i(rx_addr), .strap_i(strap_i), .hit_o(hit));

   pex_bus_engine #(.DATA_W(DATA_W)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_lvl_i(sda_lvl),
      .start_i(start_det), .stop_i(stop_det), .hit_i(hit),
      .port_in_i(port_in_i), .rx_addr_o(rx_addr), .sda_oe_o(sda_oe_o),
      .port_out_o(port_out_o), .capture_o(capture_o),
      .addr_ack_o(addr_ack_o), .data_ack_o(data_ack_o),
      .capture_p_o(capture_p_o), .update_p_o(update_p_o),
      .rd_xfer_o(rd_xfer_o));

   assert_no_drive_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stop_det) |-> !sda_oe_o)
      else $error("SDA driven right after STOP");
endmodule

// File: tb/pex_i2c_target_tb.sv
module pex_i2c_target_tb;
   localparam int Q = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [2:0] strap = 3'd0;
   logic [7:0] port_in = 8'h00;
   logic sda_oe, sda_bus;
   logic [7:0] port_out, cap;
   logic aack, dack, capp, updp, rdx;
   int n_chk = 0, n_fail = 0;
   int c_aack = 0, c_dack = 0, c_cap = 0, c_upd = 0;

   always #5 clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;

   pex_i2c_target u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe_o(sda_oe), .strap_i(strap), .port_in_i(port_in),
      .port_out_o(port_out), .capture_o(cap), .addr_ack_o(aack),
      .data_ack_o(dack), .capture_p_o(capp), .update_p_o(updp),
      .rd_xfer_o(rdx));

   always @(posedge clk) begin
      if (aack) c_aack <= c_aack + 1;
      if (dack) c_dack <= c_dack + 1;
      if (capp) c_cap  <= c_cap + 1;
      if (updp) c_upd  <= c_upd + 1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bstart;
      sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
   endtask

   task automatic bstop;
      sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
   endtask

   task automatic tx_bit(input logic b);
      sda_m = b; tick(Q); scl_m = 1; tick(Q); scl_m = 0; tick(Q);
   endtask

   task automatic rx_bit(output logic b);
      sda_m = 1; tick(Q); scl_m = 1; tick(Q/2); b = sda_bus; tick(Q/2); scl_m = 0; tick(Q);
   endtask

   task automatic ack_bit(output logic ack);
      sda_m = 1; tick(Q); scl_m = 1; tick(Q/2); ack = ~sda_bus; tick(Q/2); scl_m = 0; tick(Q);
   endtask

   task automatic addr(input logic [6:0] a, input logic rw, output logic ack);
      for (int i = 6; i >= 0; i--) tx_bit(a[i]);
      tx_bit(rw);
      ack_bit(ack);
   endtask

   task automatic addr_swap(input logic [6:0] a, input logic [2:0] ns, output logic ack);
      for (int i = 6; i >= 0; i--) tx_bit(a[i]);
      sda_m = 0; tick(Q); scl_m = 1; tick(Q/2); strap = ns; tick(Q/2); scl_m = 0; tick(Q);
      ack_bit(ack);
   endtask

   task automatic tx_byte(input logic [7:0] d, output logic ack,
                          output logic [7:0] pre, output logic [7:0] post);
      for (int i = 7; i >= 0; i--) tx_bit(d[i]);
      sda_m = 1; tick(Q); pre = port_out;
      scl_m = 1; tick(Q/2); ack = ~sda_bus; tick(Q/2); post = port_out;
      scl_m = 0; tick(Q);
   endtask

   task automatic rx_byte(input logic mack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) rx_bit(d[i]);
      sda_m = ~mack; tick(Q); scl_m = 1; tick(Q); scl_m = 0; tick(Q);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic ack;
      logic [7:0] pre, post, d;
      tick(5);
      chk("R9 port latch in reset", port_out, 8'hFF);
      chk("R9 capture in reset", cap, 8'h00);
      chk("R9 sda released in reset", sda_oe, 0);
      rst_n = 1; tick(5);

      for (int s = 0; s < 8; s++) begin
         strap = 3'(s);
         for (int k = 0; k < 9; k++) begin
            logic [6:0] a;
            a = (k < 8) ? 7'(8'h20 + k) : 7'(8'h38 + s);
            bstart; addr(a, 1'b0, ack); bstop;
            chk($sformatf("R1 addr %0h strap %0d", a, s), ack, (k == s));
         end
      end
      chk("R1 port untouched by address-only", port_out, 8'hFF);

      strap = 3; c_aack = 0; c_dack = 0; c_cap = 0; c_upd = 0;
      bstart; addr(7'h23, 1'b0, ack);
      chk("R1 write addr ack", ack, 1);
      chk("R8 write direction", rdx, 0);
      tx_byte(8'h5A, ack, pre, post);
      chk("R3 ack byte1", ack, 1); chk("R3 before rise b1", pre, 8'hFF); chk("R3 after rise b1", post, 8'h5A);
      tx_byte(8'h00, ack, pre, post);
      chk("R3 before rise b2", pre, 8'h5A); chk("R3 after rise b2", post, 8'h00);
      tx_byte(8'hC3, ack, pre, post);
      chk("R3 ack byte3", ack, 1); chk("R3 after rise b3", post, 8'hC3);
      for (int i = 0; i < 5; i++) tx_bit(i[0]);
      bstop;
      chk("R3 partial byte ignored", port_out, 8'hC3);
      chk("R8 addr ack pulses", c_aack, 1);
      chk("R8 data ack pulses", c_dack, 3);
      chk("R8 update pulses", c_upd, 3);
      chk("R8 no capture on write", c_cap, 0);

      strap = 1; bstart; addr_swap(7'h21, 3'd2, ack); bstop;
      chk("R2 strap moved away before R/W fall", ack, 0);
      strap = 1; bstart; addr_swap(7'h22, 3'd2, ack); bstop;
      chk("R2 strap moved onto address before R/W fall", ack, 1);

      strap = 6; bstart;
      tx_bit(0); tx_bit(1); tx_bit(0); tx_bit(0);
      bstart; addr(7'h26, 1'b0, ack);
      chk("R6 ack after repeated start", ack, 1);
      tx_byte(8'h81, ack, pre, post); bstop;
      chk("R6 write after repeated start", port_out, 8'h81);
      bstart; tx_bit(1); tx_bit(1); tx_bit(0);
      bstart; addr(7'h27, 1'b0, ack); bstop;
      chk("R6 wrong full address after abort", ack, 0);

      scl_m = 0; tick(Q);
      addr(7'h26, 1'b0, ack);
      chk("R7 no ack without start", ack, 0);
      tx_byte(8'h18, ack, pre, post);
      chk("R7 no data ack after stop", ack, 0);
      bstop;
      chk("R7 port unchanged after stop", port_out, 8'h81);

      strap = 5; port_in = 8'hC1; c_aack = 0; c_dack = 0; c_cap = 0; c_upd = 0;
      bstart; addr(7'h25, 1'b1, ack);
      chk("R1 read addr ack", ack, 1);
      chk("R4 captured at addr ack", cap, 8'hC1);
      port_in = 8'h3C;
      rx_byte(1'b1, d);
      chk("R4 first byte MSB first", d, 8'hC1);
      chk("R8 read direction", rdx, 1);
      chk("R5 recapture on controller ack", cap, 8'h3C);
      port_in = 8'h99;
      rx_byte(1'b0, d);
      chk("R5 second byte after recapture", d, 8'h3C);
      chk("R5 no recapture on nack", cap, 8'h3C);
      rx_byte(1'b0, d);
      chk("R5 bus released after nack", d, 8'hFF);
      bstop;
      chk("R8 read addr ack pulses", c_aack, 1);
      chk("R8 read data ack pulses", c_dack, 2);
      chk("R8 read capture pulses", c_cap, 2);
      chk("R8 no update on read", c_upd, 0);
      chk("R10 sda idle at end", sda_oe, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule